// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking an in-memory translation tree. The walk begins with one entry fetched from a context table, whose location comes from a base-pointer input and the current context number. It then descends through up to three page-table levels. A leaf entry may turn up at the first, second or third level, which maps a 16 MB, 256 KB or 4 KB page. An invalid or malformed entry ends the walk with a fault code.

When the leaf it used does not yet record a reference, or the access is a write and the leaf does not yet record a modification, the walker sets those status bits and writes the entry back to the address it was read from. When translation is switched off, the walker skips the tree and returns the virtual address unchanged, with read and write allowed. Entries arrive over a simple request/valid read port that has one read in flight at a time. Permission checks and translation caching sit in other blocks.

Top module: `pgwalk_top`

## Requirements
- R1: With `mmuOn` low at start, `done` pulses one cycle after the start edge with `paddr` equal to the zero-extended `vaddr`, `passRW`=1, `pageSize`=3, `faultCode`=0, and no read is issued.
- R2: The first read of a walk is at address `ctxBase`*16 + `ctxNum`*16.
- R3: Bits [1:0] of every entry give its type: 0 invalid, 1 table descriptor, 2 leaf, 3 reserved.
- R4: A descriptor's table base is entry[31:2]*64. The next read is at that base plus 4 times VA[31:24] (level 1), VA[23:18] (level 2) or VA[17:12] (level 3).
- R5: A leaf at level 1 reports `pageSize`=2 with offset VA[23:0]. At level 2 it reports 1 with offset VA[17:0]. At level 3 it reports 0 with offset VA[11:0].
- R6: On success `paddr` = entry[31:8]*4096 + offset and `faultCode`=0.
- R7: An invalid entry at any level ends the walk with `faultCode`=1.
- R8: A reserved entry, a leaf in the context table or a descriptor at level 3 ends the walk with `faultCode`=4. No fault of any kind writes memory.
- R9: Entry bit 5 is the referenced bit and bit 6 the modified bit. If bit 5 is clear, or `isWrite` is high and bit 6 is clear, the walker issues exactly one write of the entry with bit 5 set, and with bit 6 set when `isWrite` is high. The write goes to the leaf's read address in the cycle before `done`. Otherwise it issues no write.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. `done` is a one-cycle pulse. At most one read is outstanding. A start while busy is ignored, and the result belongs to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | Access is a write |
| mmuOn | input | 1 | Translation enabled |
| ctxBase | input | 32 | Context-table base pointer |
| ctxNum | input | CTX_W | Current context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| paddr | output | 36 | Physical address (don't-care on fault) |
| pageSize | output | 2 | 0=4 KB, 1=256 KB, 2=16 MB, 3=pass-through |
| faultCode | output | 3 | 0 ok, 1 invalid entry, 4 bad entry type |
| passRW | output | 1 | Translation off, read and write allowed |
| rdReq | output | 1 | Read request strobe |
| rdAddr | output | 36 | Entry read address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Entry read data |
| wrReq | output | 1 | Entry write-back strobe |
| wrAddr | output | 36 | Write-back address |
| wrData | output | 32 | Updated entry |

## Verification
The bench places a leaf at each of the three levels. For each placement it sweeps spread-out virtual addresses, both access kinds and all four combinations of the referenced and modified bits. This separates the offset width and the size code of each level, and it separates the cases that need a write-back from those that do not. Read latency is varied from one to three cycles, and each read address of the walk is compared against the address computed from the context number and the virtual-address index fields. Invalid and reserved entries are placed at every depth, alongside a leaf in the context table and a descriptor at level 3, to tell fault code 1 from code 4 and to confirm that no fault writes memory. Pass-through addresses and a second start issued during a walk complete the sweep.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ENT_W  = 32;
  localparam int VA_W   = 32;
  localparam int BASE_W = 32;
  localparam int PA_W   = BASE_W + 4;

  localparam logic [1:0] TY_INVALID = 2'd0;
  localparam logic [1:0] TY_TABLE   = 2'd1;
  localparam logic [1:0] TY_LEAF    = 2'd2;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;
  localparam logic [1:0] SZ_PASS = 2'd3;

  localparam logic [2:0] FC_NONE    = 3'd0;
  localparam logic [2:0] FC_INVALID = 3'd1;
  localparam logic [2:0] FC_BADTYPE = 3'd4;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic       capture;
    logic       bypass;
    logic       descend;
    logic       leaf;
    logic       setFault;
    logic [2:0] code;
  } walkCmd_t;
endpackage

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isWrite,
  input  logic [BASE_W-1:0] ctxBase,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [ENT_W-1:0]  rdData,
  output logic [1:0]        level,
  output logic              needWb,
  output logic [PA_W-1:0]   rdAddr,
  output logic [ENT_W-1:0]  wrData,
  output logic [PA_W-1:0]   paddr,
  output logic [1:0]        pageSize,
  output logic [2:0]        faultCode,
  output logic              passRW
);
  localparam int CTX_PAD = PA_W - CTX_W - 4;

  logic [VA_W-1:0]  vaReg;
  logic             wrReg;
  logic [PA_W-1:0]  ctxAddr, tblBase, nextAddr, leafPa;
  logic [9:0]       idxOff;
  logic [23:0]      pageOff;
  logic [1:0]       leafSize;
  logic [ENT_W-1:0] newEntry;

  always_comb begin
    ctxAddr = {ctxBase, 4'b0} + {{CTX_PAD{1'b0}}, ctxNum, 4'b0};
    tblBase = {rdData[ENT_W-1:2], 6'b0};
    case (level)
      2'd0:    idxOff = {vaReg[31:24], 2'b00};
      2'd1:    idxOff = {2'b00, vaReg[23:18], 2'b00};
      default: idxOff = {2'b00, vaReg[17:12], 2'b00};
    endcase
    nextAddr = tblBase + PA_W'(idxOff);
    case (level)
      2'd1: begin pageOff = vaReg[23:0];          leafSize = SZ_16M;  end
      2'd2: begin pageOff = {6'b0, vaReg[17:0]};  leafSize = SZ_256K; end
      default: begin pageOff = {12'b0, vaReg[11:0]}; leafSize = SZ_4K; end
    endcase
    leafPa   = {rdData[ENT_W-1:8], 12'b0} + PA_W'(pageOff);
    needWb   = !rdData[REF_BIT] || (wrReg && !rdData[MOD_BIT]);
    newEntry = rdData;
    newEntry[REF_BIT] = 1'b1;
    if (wrReg) newEntry[MOD_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      wrReg     <= 1'b0;
      level     <= 2'd0;
      rdAddr    <= '0;
      wrData    <= '0;
      paddr     <= '0;
      pageSize  <= SZ_4K;
      faultCode <= FC_NONE;
      passRW    <= 1'b0;
    end else begin
      if (cmd.capture) begin
        vaReg     <= vaddr;
        wrReg     <= isWrite;
        level     <= 2'd0;
        rdAddr    <= ctxAddr;
        faultCode <= FC_NONE;
        passRW    <= 1'b0;
      end
      if (cmd.bypass) begin
        paddr     <= PA_W'(vaddr);
        pageSize  <= SZ_PASS;
        faultCode <= FC_NONE;
        passRW    <= 1'b1;
      end
      if (cmd.descend) begin
        level  <= level + 2'd1;
        rdAddr <= nextAddr;
      end
      if (cmd.leaf) begin
        paddr    <= leafPa;
        pageSize <= leafSize;
        wrData   <= newEntry;
      end
      if (cmd.setFault) faultCode <= cmd.code;
    end
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       mmuOn,
  input  logic       rdValid,
  input  logic [1:0] entryType,
  input  logic [1:0] level,
  input  logic       needWb,
  output walkCmd_t   cmd,
  output logic       rdReq,
  output logic       wrReq,
  output logic       busy,
  output logic       done
);
  walkState_t state, nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        if (mmuOn) begin
          cmd.capture = 1'b1;
          nextState   = ST_READ;
        end else begin
          cmd.bypass = 1'b1;
          nextState  = ST_DONE;
        end
      end
      ST_READ: nextState = ST_WAIT;
      ST_WAIT: if (rdValid) begin
        case (entryType)
          TY_INVALID: begin
            cmd.setFault = 1'b1;
            cmd.code     = FC_INVALID;
            nextState    = ST_DONE;
          end
          TY_TABLE: begin
            if (level == 2'd3) begin
              cmd.setFault = 1'b1;
              cmd.code     = FC_BADTYPE;
              nextState    = ST_DONE;
            end else begin
              cmd.descend = 1'b1;
              nextState   = ST_READ;
            end
          end
          TY_LEAF: begin
            if (level == 2'd0) begin
              cmd.setFault = 1'b1;
              cmd.code     = FC_BADTYPE;
              nextState    = ST_DONE;
            end else begin
              cmd.leaf  = 1'b1;
              nextState = needWb ? ST_WRITE : ST_DONE;
            end
          end
          default: begin
            cmd.setFault = 1'b1;
            cmd.code     = FC_BADTYPE;
            nextState    = ST_DONE;
          end
        endcase
      end
      ST_WRITE: nextState = ST_DONE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign rdReq = (state == ST_READ);
  assign wrReq = (state == ST_WRITE);
  assign done  = (state == ST_DONE);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isWrite,
  input  logic              mmuOn,
  input  logic [BASE_W-1:0] ctxBase,
  input  logic [CTX_W-1:0]  ctxNum,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   paddr,
  output logic [1:0]        pageSize,
  output logic [2:0]        faultCode,
  output logic              passRW,
  output logic              rdReq,
  output logic [PA_W-1:0]   rdAddr,
  input  logic              rdValid,
  input  logic [ENT_W-1:0]  rdData,
  output logic              wrReq,
  output logic [PA_W-1:0]   wrAddr,
  output logic [ENT_W-1:0]  wrData
);
  walkCmd_t   cmd;
  logic [1:0] level;
  logic       needWb;

  pgwalk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mmuOn(mmuOn),
    .rdValid(rdValid), .entryType(rdData[1:0]), .level(level),
    .needWb(needWb), .cmd(cmd), .rdReq(rdReq), .wrReq(wrReq),
    .busy(busy), .done(done)
  );

  pgwalk_dpath #(.CTX_W(CTX_W)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .vaddr(vaddr), .isWrite(isWrite),
    .ctxBase(ctxBase), .ctxNum(ctxNum), .rdData(rdData), .level(level),
    .needWb(needWb), .rdAddr(rdAddr), .wrData(wrData), .paddr(paddr),
    .pageSize(pageSize), .faultCode(faultCode), .passRW(passRW)
  );

  assign wrAddr = rdAddr;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [2:0]      faultCode,
  input logic            passRW,
  input logic            rdReq,
  input logic [PA_W-1:0] rdAddr,
  input logic            rdValid,
  input logic            wrReq,
  input logic [PA_W-1:0] wrAddr,
  input logic [ENT_W-1:0] wrData
);
  logic [1:0]      inFlight;
  logic [2:0]      walkReads;
  logic [PA_W-1:0] lastRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight  <= '0;
      walkReads <= '0;
      lastRd    <= '0;
    end else begin
      inFlight <= inFlight + {1'b0, rdReq} - {1'b0, rdValid};
      if (start && !busy) walkReads <= '0;
      else if (rdReq)     walkReads <= walkReads + 3'd1;
      if (rdReq) lastRd <= rdAddr;
    end
  end

  // R10: one read in flight at most
  a_r10_one_read: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> inFlight == 2'd0);
  // R10: done is a single pulse followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);
  // R1: pass-through makes no reads
  a_r1_no_read: assert property (@(posedge clk) disable iff (!rstN)
    done && passRW |-> walkReads == 3'd0);
  // R9: write-back goes to the address last read, with referenced bit set
  a_r9_wb_addr: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> wrAddr == lastRd && wrData[REF_BIT]);
  // R8: a write-back is only followed by a successful completion
  a_r8_wb_ok: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> done && faultCode == FC_NONE);
  // R2: entry addresses are word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[1:0] == 2'b00);
  // R4: a walk reads at most four entries
  a_r4_depth: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> walkReads < 3'd4);
endmodule

bind pgwalk_top pgwalk_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .faultCode(faultCode), .passRW(passRW), .rdReq(rdReq), .rdAddr(rdAddr),
  .rdValid(rdValid), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic        mmuOn = 1'b0;
  logic [31:0] ctxBase = 32'h100;
  logic [7:0]  ctxNum = '0;
  logic        busy, done, passRW, rdReq, wrReq;
  logic [35:0] paddr, rdAddr, wrAddr;
  logic [1:0]  pageSize;
  logic [2:0]  faultCode;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [31:0] wrData;

  always #10 clk = ~clk;

  pgwalk_top u0 (.*);

  logic [31:0] mem [logic [35:0]];
  int          lat = 1;
  int          pendCnt = 0;
  logic [35:0] pendAddr = '0;
  int          rdCnt = 0, wrCnt = 0;
  logic [35:0] rdLog [4];
  logic [35:0] lastWrA = '0;
  logic [31:0] lastWrD = '0;
  int          nChecks = 0, nFails = 0, cycles = 0;

  function automatic logic [31:0] memRd(input logic [35:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    rdValid <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        rdValid <= 1'b1;
        rdData  <= memRd(pendAddr);
      end
    end
    if (rdReq) begin
      pendAddr <= rdAddr;
      pendCnt  <= lat;
      if (rdCnt < 4) rdLog[rdCnt] = rdAddr;
      rdCnt = rdCnt + 1;
    end
    if (wrReq) begin
      mem[wrAddr] = wrData;
      lastWrA = wrAddr;
      lastWrD = wrData;
      wrCnt = wrCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        nFails++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  function automatic logic [35:0] lvlAddr(input int l, input logic [31:0] va, input logic [7:0] c);
    case (l)
      0: return 36'h1000 + 36'(c) * 16;
      1: return 36'h2000 + 36'(va[31:24]) * 4;
      2: return 36'h4000 + 36'(va[23:18]) * 4;
      default: return 36'h8000 + 36'(va[17:12]) * 4;
    endcase
  endfunction

  // descriptors at levels below depth, lastEnt at depth
  task automatic buildPath(input logic [31:0] va, input logic [7:0] c, input int depth,
                           input logic [31:0] lastEnt);
    mem.delete();
    for (int l = 0; l < depth; l++) begin
      case (l)
        0: mem[lvlAddr(0, va, c)] = 32'h201;
        1: mem[lvlAddr(1, va, c)] = 32'h401;
        default: mem[lvlAddr(2, va, c)] = 32'h801;
      endcase
    end
    mem[lvlAddr(depth, va, c)] = lastEnt;
  endtask

  task automatic runWalk(input logic [31:0] va, input logic w, input logic [7:0] c,
                         input logic on);
    vaddr = va; isWrite = w; ctxNum = c; mmuOn = on;
    rdCnt = 0; wrCnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n < 80 && !done; n++) @(negedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R10 no done actual=0 expected=1");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset rdReq", rdReq, 0);
    chk("R9 reset wrReq", wrReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: pass-through
    for (int i = 0; i < 6; i++) begin
      logic [31:0] va;
      va = 32'((i + 1) * 32'h9E3779B1);
      runWalk(va, i[0], 8'(i), 1'b0);
      chk("R1 paddr", paddr, {4'h0, va});
      chk("R1 passRW", passRW, 1);
      chk("R1 size", pageSize, 3);
      chk("R1 fault", faultCode, 0);
      chk("R1 reads", rdCnt, 0);
      @(negedge clk);
    end

    // R5 R6 R9: leaf at each level, all R/M combos, both access kinds
    for (int lv = 1; lv <= 3; lv++) begin
      for (int i = 0; i < 6; i++) begin
        for (int w = 0; w < 2; w++) begin
          for (int rm = 0; rm < 4; rm++) begin
            logic [31:0] va, ent, expWb;
            logic [23:0] ppn;
            logic [35:0] expPa, off;
            logic [7:0]  c;
            logic        need;
            va  = 32'((i + 3) * 32'h7F4A7C15 + lv * 32'h01234567);
            c   = 8'(i * 37 + lv);
            ppn = 24'(24'h0ABC0 + i * 24'h1357 + rm);
            ent = {ppn, 1'b0, rm[1], rm[0], 3'b011, 2'b10};
            buildPath(va, c, lv, ent);
            lat = 1 + (i % 3);
            runWalk(va, w[0], c, 1'b1);
            case (lv)
              1: off = 36'(va[23:0]);
              2: off = 36'(va[17:0]);
              default: off = 36'(va[11:0]);
            endcase
            expPa = {ppn, 12'h0} + off;
            chk("R6 paddr", paddr, expPa);
            chk("R6 fault", faultCode, 0);
            chk("R5 size", pageSize, (lv == 1) ? 2 : (lv == 2) ? 1 : 0);
            chk("R10 passRW low", passRW, 0);
            chk("R4 read count", rdCnt, lv + 1);
            chk("R2 ctx addr", rdLog[0], lvlAddr(0, va, c));
            for (int l = 1; l <= lv; l++) chk("R4 table addr", rdLog[l], lvlAddr(l, va, c));
            need  = !rm[0] || (w[0] && !rm[1]);
            expWb = ent | 32'h20 | (w[0] ? 32'h40 : 32'h0);
            chk("R9 write count", wrCnt, need ? 1 : 0);
            if (need) begin
              chk("R9 wb addr", lastWrA, lvlAddr(lv, va, c));
              chk("R9 wb data", lastWrD, expWb);
            end
            @(negedge clk);
          end
        end
      end
    end

    // R7 R8 R3: faults at every depth
    for (int d = 0; d <= 3; d++) begin
      for (int t = 0; t < 4; t++) begin
        logic [31:0] va;
        logic [2:0]  expF;
        va = 32'((d + 1) * 32'h6B43A9B5 + t * 32'h11111);
        if (t == 0) expF = 3'd1;
        else if (t == 3) expF = 3'd4;
        else if (t == 2 && d == 0) expF = 3'd4;
        else if (t == 1 && d == 3) expF = 3'd4;
        else continue;
        buildPath(va, 8'(d * 5), d, 32'hFFFFFF60 | 32'(t));
        lat = 2;
        runWalk(va, 1'b1, 8'(d * 5), 1'b1);
        if (t == 0) chk("R7 invalid fault", faultCode, expF);
        else        chk("R8 bad type fault", faultCode, expF);
        chk("R8 no write on fault", wrCnt, 0);
        chk("R3 reads to fault", rdCnt, d + 1);
        @(negedge clk);
      end
    end

    // R10: start while busy is ignored
    begin
      logic [31:0] va1;
      va1 = 32'h12345678;
      buildPath(va1, 8'd9, 3, 32'h00ABCD62);
      lat = 3;
      vaddr = va1; isWrite = 1'b0; ctxNum = 8'd9; mmuOn = 1'b1;
      rdCnt = 0; wrCnt = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R10 busy after start", busy, 1);
      repeat (2) @(negedge clk);
      vaddr = 32'hFEDCBA98; mmuOn = 1'b0; start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int n = 0; n < 80 && !done; n++) @(negedge clk);
      chk("R10 ignored start paddr", paddr, {24'h00ABCD, 12'h678});
      chk("R10 ignored start passRW", passRW, 0);
      chk("R10 busy in done", busy, 1);
      @(negedge clk);
      chk("R10 done pulse", done, 0);
      chk("R10 idle after done", busy, 0);
    end

    finishRun();
  end
endmodule